// File: doc/BRIEF.md
# Keyed Overlay Table and Colour-Bar Source

This block chooses, pixel by pixel, the video that feeds the downstream composite encoder and the RGB output path. Each active pixel arrives as one luma byte plus one chroma byte in a 4:2:2 stream: the chroma byte carries Cb on even pixels and Cr on odd pixels. An overlay key and a 3-bit overlay index can replace the incoming pixel with an entry from an 8-entry colour table. Each entry holds Y, Cb and Cr.

A configuration bit removes the keying from the encode path only. Overlay graphics then appear on the RGB output and stay off the composite picture. A second configuration bit turns the same table into a colour-bar source. The eight entries are shown in order, in eight equal steps across every active line, and the external pixels are ignored. After reset the table holds the standard 100% bar colours, and software may rewrite it one byte at a time.

Both output paths are registered and appear one clock after the input pixel.

Top module: `pix_key_mux`

## Requirements
- R1: While reset is asserted, all outputs are zero, including out_active.
- R2: During an active line with bar mode off and the key low, both paths output the input luma and chroma unchanged.
- R3: During an active line with bar mode off and the key high, the RGB path luma is the Y byte of the table entry selected by ovl_idx.
- R4: Pixels are numbered from 0 at the first active cycle of each line; even pixels carry Cb and odd pixels carry Cr. The key and index sampled on an even pixel decide the chroma of that pixel and of the following odd pixel, giving Cb then Cr of the same entry. Luma follows each pixel's own key.
- R5: With enc_key_dis set, the encode path ignores the key and passes the input. The RGB path stays keyed.
- R6: With bar_en set during an active line, both paths show table entry min(n / W, 7), where n is the pixel number and W is ACTIVE_PIX/8 rounded down to an even value (90 for 720). Chroma is Cb on even n and Cr on odd n. Key, ovl_idx and the input data have no effect, and the sequence restarts on each line.
- R7: After reset the table entries 0 to 7 hold, as Y/Cb/Cr: 235/128/128, 210/16/146, 170/166/16, 145/54/34, 106/202/222, 81/90/240, 41/240/110, 16/128/128.
- R8: A write with wr_en high stores wr_data into entry wr_addr, in field Y for wr_sel 0, Cb for 1 and Cr for 2; wr_sel 3 stores nothing. A pixel on the same clock as the write still sees the old value, and the next pixel sees the new one.
- R9: While line_active is low, both paths output the input luma and chroma, whatever the key and bar_en are.
- R10: Every output appears one clock after its input pixel, and out_active is line_active delayed by one clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| line_active | input | 1 | High for each active pixel of a line |
| in_y | input | 8 | Main input luma |
| in_c | input | 8 | Main input chroma (Cb on even pixels, Cr on odd pixels) |
| key | input | 1 | Overlay key, high selects the table |
| ovl_idx | input | IDXW | Overlay table index |
| bar_en | input | 1 | Colour-bar mode enable bit |
| enc_key_dis | input | 1 | Disables keying on the encode path |
| wr_en | input | 1 | Table write strobe |
| wr_addr | input | IDXW | Table entry to write |
| wr_sel | input | 2 | Field select: 0 Y, 1 Cb, 2 Cr, 3 none |
| wr_data | input | 8 | Byte to write |
| enc_y | output | 8 | Encode path luma |
| enc_c | output | 8 | Encode path chroma |
| rgb_y | output | 8 | RGB path luma |
| rgb_c | output | 8 | RGB path chroma |
| out_active | output | 1 | Delayed line_active |

## Verification
The assertions check the following on every cycle:
- the one-clock latency of out_active;
- pass-through outside the active line;
- pass-through with the key low;
- the encode path ignoring the key when keying is disabled there;
- both paths agreeing in bar mode.

Some behaviour depends on table contents and on the pixel position in the line, so only the bench's scenarios can show it:
- the chroma pairing of keyed pixels;
- the exact bar colours and step edges at multiples of 90 pixels;
- the clamp to the last bar;
- the timing of table writes against reads on the same clock.

// File: rtl/keysel_pkg.sv
package keysel_pkg;
    localparam int PIXW = 8;

    localparam logic [1:0] SEL_Y  = 2'd0;
    localparam logic [1:0] SEL_CB = 2'd1;
    localparam logic [1:0] SEL_CR = 2'd2;

    typedef struct packed {
        logic [PIXW-1:0] y;
        logic [PIXW-1:0] cb;
        logic [PIXW-1:0] cr;
    } ycc_t;

    // Standard 100% bars, brightest first
    function automatic ycc_t bar_colour(input int unsigned n);
        ycc_t c;
        case (n)
            0:       c = '{y: 8'd235, cb: 8'd128, cr: 8'd128};
            1:       c = '{y: 8'd210, cb: 8'd16,  cr: 8'd146};
            2:       c = '{y: 8'd170, cb: 8'd166, cr: 8'd16};
            3:       c = '{y: 8'd145, cb: 8'd54,  cr: 8'd34};
            4:       c = '{y: 8'd106, cb: 8'd202, cr: 8'd222};
            5:       c = '{y: 8'd81,  cb: 8'd90,  cr: 8'd240};
            6:       c = '{y: 8'd41,  cb: 8'd240, cr: 8'd110};
            default: c = '{y: 8'd16,  cb: 8'd128, cr: 8'd128};
        endcase
        return c;
    endfunction
endpackage

// File: rtl/keysel_lut.sv
module keysel_lut
    import keysel_pkg::*;
#(
    parameter int IDXW = 3
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          wr_en,
    input  logic [IDXW-1:0]               wr_addr,
    input  logic [1:0]                    wr_sel,
    input  logic [PIXW-1:0]               wr_data,
    output ycc_t [(1<<IDXW)-1:0]          tab_o
);
    localparam int ENTRIES = 1 << IDXW;

    ycc_t [ENTRIES-1:0] tab_d, tab_q;

    always_comb begin
        tab_d = tab_q;
        if (wr_en) begin
            case (wr_sel)
                SEL_Y:   tab_d[wr_addr].y  = wr_data;
                SEL_CB:  tab_d[wr_addr].cb = wr_data;
                SEL_CR:  tab_d[wr_addr].cr = wr_data;
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < ENTRIES; i++) begin
                tab_q[i] <= bar_colour(i);
            end
        end else begin
            tab_q <= tab_d;
        end
    end

    assign tab_o = tab_q;
endmodule

// File: rtl/keysel_bartimer.sv
module keysel_bartimer #(
    parameter int ACTIVE_PIX = 720,
    parameter int IDXW       = 3
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            line_active,
    output logic            odd_px,
    output logic [IDXW-1:0] bar_idx
);
    localparam int STEPS    = 1 << IDXW;
    localparam int STEP_RAW = ACTIVE_PIX / STEPS;
    localparam int STEP_W   = (STEP_RAW < 2) ? 2 : (STEP_RAW - (STEP_RAW % 2));
    localparam int CW       = $clog2(STEP_W);

    typedef struct packed {
        logic            odd;
        logic [CW-1:0]   cnt;
        logic [IDXW-1:0] bar;
    } tmr_t;

    tmr_t tmr_d, tmr_q;

    always_comb begin
        tmr_d = tmr_q;
        if (!line_active) begin
            tmr_d = '0;
        end else begin
            tmr_d.odd = !tmr_q.odd;
            if (tmr_q.cnt == CW'(STEP_W - 1)) begin
                tmr_d.cnt = '0;
                if (tmr_q.bar != IDXW'(STEPS - 1)) begin
                    tmr_d.bar = tmr_q.bar + 1'b1;
                end
            end else begin
                tmr_d.cnt = tmr_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tmr_q <= '0;
        end else begin
            tmr_q <= tmr_d;
        end
    end

    assign odd_px  = tmr_q.odd;
    assign bar_idx = tmr_q.bar;
endmodule

// File: rtl/pix_key_mux.sv
module pix_key_mux
    import keysel_pkg::*;
#(
    parameter int ACTIVE_PIX = 720,
    parameter int IDXW       = 3
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            line_active,
    input  logic [7:0]      in_y,
    input  logic [7:0]      in_c,
    input  logic            key,
    input  logic [IDXW-1:0] ovl_idx,
    input  logic            bar_en,
    input  logic            enc_key_dis,
    input  logic            wr_en,
    input  logic [IDXW-1:0] wr_addr,
    input  logic [1:0]      wr_sel,
    input  logic [7:0]      wr_data,
    output logic [7:0]      enc_y,
    output logic [7:0]      enc_c,
    output logic [7:0]      rgb_y,
    output logic [7:0]      rgb_c,
    output logic            out_active
);
    localparam int ENTRIES = 1 << IDXW;
    localparam int NPATH   = 2;   // 0: RGB path, 1: encode path

    typedef struct packed {
        logic            pair_key;
        logic [IDXW-1:0] pair_idx;
        logic            act;
        logic [PIXW-1:0] ey;
        logic [PIXW-1:0] ec;
        logic [PIXW-1:0] ry;
        logic [PIXW-1:0] rc;
    } st_t;

    st_t st_d, st_q;

    ycc_t [ENTRIES-1:0] tab;
    logic               odd_px;
    logic [IDXW-1:0]    bar_idx;

    keysel_lut #(.IDXW(IDXW)) u_lut (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_sel  (wr_sel),
        .wr_data (wr_data),
        .tab_o   (tab)
    );

    keysel_bartimer #(.ACTIVE_PIX(ACTIVE_PIX), .IDXW(IDXW)) u_tmr (
        .clk         (clk),
        .rst_n       (rst_n),
        .line_active (line_active),
        .odd_px      (odd_px),
        .bar_idx     (bar_idx)
    );

    logic            even_px;
    logic            cur_pkey;
    logic [IDXW-1:0] cur_pidx;
    ycc_t            ovl_ent, pair_ent, bar_ent;
    logic [PIXW-1:0] ovl_c, bar_c;
    logic [NPATH-1:0] key_ok;
    logic [PIXW-1:0] py [NPATH];
    logic [PIXW-1:0] pc [NPATH];

    always_comb begin
        st_d     = st_q;
        even_px  = !odd_px;
        // chroma pair is decided on the even (Cb) pixel
        cur_pkey = even_px ? key     : st_q.pair_key;
        cur_pidx = even_px ? ovl_idx : st_q.pair_idx;
        ovl_ent  = tab[ovl_idx];
        pair_ent = tab[cur_pidx];
        bar_ent  = tab[bar_idx];
        ovl_c    = even_px ? pair_ent.cb : pair_ent.cr;
        bar_c    = even_px ? bar_ent.cb  : bar_ent.cr;
        key_ok   = {!enc_key_dis, 1'b1};

        for (int p = 0; p < NPATH; p++) begin
            if (!line_active) begin
                py[p] = in_y;
                pc[p] = in_c;
            end else if (bar_en) begin
                py[p] = bar_ent.y;
                pc[p] = bar_c;
            end else begin
                py[p] = (key && key_ok[p])      ? ovl_ent.y : in_y;
                pc[p] = (cur_pkey && key_ok[p]) ? ovl_c     : in_c;
            end
        end

        st_d.pair_key = line_active ? cur_pkey : 1'b0;
        st_d.pair_idx = line_active ? cur_pidx : '0;
        st_d.act      = line_active;
        st_d.ry       = py[0];
        st_d.rc       = pc[0];
        st_d.ey       = py[1];
        st_d.ec       = pc[1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign enc_y      = st_q.ey;
    assign enc_c      = st_q.ec;
    assign rgb_y      = st_q.ry;
    assign rgb_c      = st_q.rc;
    assign out_active = st_q.act;
endmodule

// File: rtl/keysel_chk.sv
module keysel_chk #(
    parameter int IDXW = 3
) (
    input logic            clk,
    input logic            rst_n,
    input logic            line_active,
    input logic [7:0]      in_y,
    input logic [7:0]      in_c,
    input logic            key,
    input logic [IDXW-1:0] ovl_idx,
    input logic            bar_en,
    input logic            enc_key_dis,
    input logic            wr_en,
    input logic [IDXW-1:0] wr_addr,
    input logic [1:0]      wr_sel,
    input logic [7:0]      wr_data,
    input logic [7:0]      enc_y,
    input logic [7:0]      enc_c,
    input logic [7:0]      rgb_y,
    input logic [7:0]      rgb_c,
    input logic            out_active
);
    logic armed_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) armed_q <= 1'b0;
        else        armed_q <= 1'b1;
    end

    // R10
    out_active_follows_chk: assert property (@(posedge clk) disable iff (!rst_n || !armed_q)
        out_active == $past(line_active));

    // R9
    blank_pass_chk: assert property (@(posedge clk) disable iff (!rst_n || !armed_q)
        !$past(line_active) |-> (rgb_y == $past(in_y) && rgb_c == $past(in_c) &&
                                 enc_y == $past(in_y) && enc_c == $past(in_c)));

    // R2
    nokey_luma_pass_chk: assert property (@(posedge clk) disable iff (!rst_n || !armed_q)
        $past(line_active && !bar_en && !key) |-> (rgb_y == $past(in_y) && enc_y == $past(in_y)));

    // R5
    enc_keyoff_chk: assert property (@(posedge clk) disable iff (!rst_n || !armed_q)
        $past(line_active && !bar_en && enc_key_dis) |->
            (enc_y == $past(in_y) && enc_c == $past(in_c)));

    // R6
    bar_paths_equal_chk: assert property (@(posedge clk) disable iff (!rst_n || !armed_q)
        $past(line_active && bar_en) |-> (enc_y == rgb_y && enc_c == rgb_c));
endmodule

bind pix_key_mux keysel_chk #(.IDXW(IDXW)) u_keysel_chk (.*);

// File: tb/tb_pix_key_mux.sv
module tb_pix_key_mux;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       line_active = 1'b0;
    logic [7:0] in_y = '0, in_c = '0;
    logic       key = 1'b0;
    logic [2:0] ovl_idx = '0;
    logic       bar_en = 1'b0, enc_key_dis = 1'b0;
    logic       wr_en = 1'b0;
    logic [2:0] wr_addr = '0;
    logic [1:0] wr_sel = '0;
    logic [7:0] wr_data = '0;
    logic [7:0] enc_y, enc_c, rgb_y, rgb_c;
    logic       out_active;

    pix_key_mux dut (.*);

    always #10 clk = !clk;

    int n_cmp = 0, n_bad = 0;
    string cur_req = "R1";

    // behavioural reference state
    int ty [8] = '{235, 210, 170, 145, 106, 81, 41, 16};
    int tcb[8] = '{128, 16, 166, 54, 202, 90, 240, 128};
    int tcr[8] = '{128, 146, 16, 34, 222, 240, 110, 128};
    int pix = 0;
    int m_pkey = 0, m_pidx = 0;

    task automatic summary();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    endtask

    task automatic cyc();
        int ey, ec, ry, rc, act, ck, ci, bi, ov_c;
        bit even;
        even = (pix % 2) == 0;
        act  = line_active;
        ck   = even ? int'(key) : m_pkey;
        ci   = even ? int'(ovl_idx) : m_pidx;
        if (!line_active) begin
            ry = in_y; rc = in_c; ey = in_y; ec = in_c;
        end else if (bar_en) begin
            bi = pix / 90; if (bi > 7) bi = 7;
            ry = ty[bi]; rc = even ? tcb[bi] : tcr[bi];
            ey = ry; ec = rc;
        end else begin
            ov_c = even ? tcb[ci] : tcr[ci];
            ry = key ? ty[ovl_idx] : int'(in_y);
            rc = ck ? ov_c : int'(in_c);
            ey = (key && !enc_key_dis) ? ty[ovl_idx] : int'(in_y);
            ec = (ck && !enc_key_dis) ? ov_c : int'(in_c);
        end
        // advance model
        if (line_active) begin
            if (even) begin m_pkey = ck; m_pidx = ci; end
            pix++;
        end else begin
            pix = 0;
        end
        if (wr_en) begin
            case (wr_sel)
                2'd0: ty[wr_addr]  = wr_data;
                2'd1: tcb[wr_addr] = wr_data;
                2'd2: tcr[wr_addr] = wr_data;
                default: ;
            endcase
        end
        @(posedge clk);
        #2;
        n_cmp++;
        if (int'(enc_y) != ey || int'(enc_c) != ec || int'(rgb_y) != ry ||
            int'(rgb_c) != rc || int'(out_active) != act) begin
            n_bad++;
            $display("FAIL %s: act enc %0d/%0d rgb %0d/%0d oa %0d, exp enc %0d/%0d rgb %0d/%0d oa %0d",
                     cur_req, enc_y, enc_c, rgb_y, rgb_c, out_active, ey, ec, ry, rc, act);
        end
    endtask

    task automatic rnd_pix(input bit la, input int key_mode);
        line_active = la;
        in_y    = 8'($urandom);
        in_c    = 8'($urandom);
        ovl_idx = 3'($urandom);
        key     = (key_mode == 2) ? 1'($urandom) : 1'(key_mode);
    endtask

    task automatic line(input int n, input int key_mode);
        for (int i = 0; i < n; i++) begin
            rnd_pix(1'b1, key_mode);
            cyc();
        end
        for (int i = 0; i < 2; i++) begin
            rnd_pix(1'b0, 2);
            cyc();
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: run did not finish, expected completion");
        summary();
        $finish;
    end

    initial begin
        // R1: reset state with busy inputs
        line_active = 1'b1; key = 1'b1; in_y = 8'hAA; in_c = 8'h55;
        repeat (3) @(posedge clk);
        #2;
        n_cmp++;
        if ({enc_y, enc_c, rgb_y, rgb_c, out_active} !== 33'd0) begin
            n_bad++;
            $display("FAIL R1: act %h/%h/%h/%h/%b exp all zero",
                     enc_y, enc_c, rgb_y, rgb_c, out_active);
        end
        line_active = 1'b0; key = 1'b0;
        rst_n = 1'b1;

        // R9 / R10: blanking with the key and bars asserted
        cur_req = "R9";
        bar_en = 1'b1;
        for (int i = 0; i < 6; i++) begin rnd_pix(1'b0, 1); cyc(); end
        bar_en = 1'b0;

        cur_req = "R2";
        line(40, 0);
        cur_req = "R3";
        line(40, 1);
        cur_req = "R4";
        line(60, 2);
        line(7, 2);

        cur_req = "R5";
        enc_key_dis = 1'b1;
        line(40, 2);
        enc_key_dis = 1'b0;

        // R7: default colours seen through bars, external data ignored
        cur_req = "R7";
        bar_en = 1'b1;
        line(740, 2);
        bar_en = 1'b0;

        // R8: write on the same clock as a keyed read of that entry
        cur_req = "R8";
        rnd_pix(1'b1, 1); ovl_idx = 3'd2;
        wr_en = 1'b1; wr_addr = 3'd2; wr_sel = 2'd0; wr_data = 8'h55;
        cyc();
        wr_en = 1'b0;
        rnd_pix(1'b1, 1); ovl_idx = 3'd2;
        cyc();
        for (int i = 0; i < 120; i++) begin
            rnd_pix(1'b1, 2);
            wr_en = 1'($urandom); wr_addr = 3'($urandom);
            wr_sel = 2'($urandom); wr_data = 8'($urandom);
            cyc();
        end
        wr_en = 1'b0;
        rnd_pix(1'b0, 0); cyc();

        // R6: bars from the rewritten table, restart per line
        cur_req = "R6";
        bar_en = 1'b1;
        line(740, 2);
        line(100, 2);
        bar_en = 1'b0;

        cur_req = "R10";
        line(9, 2);

        summary();
        $finish;
    end
endmodule